// File: doc/BRIEF.md
# Serial Adapter Bus Front End

This block is the processor-facing side of an asynchronous serial adapter. A small register window sits behind two register-select lines. The window holds a transmit holding register that can only be written, a receive holding register that can only be read, a status byte and a command byte. A transfer takes place on any fast-clock cycle in which the bus phase input is high and the chip select is asserted. The read/write line sets the direction: high means the processor reads, low means it writes.

The serial shifters and the baud generator are outside the block. They connect through simple handshakes. A one-cycle receive strobe carries a received frame. A one-cycle taken strobe says that the transmitter has consumed the held byte. Two level inputs carry the modem lines. The block produces an active-low interrupt request from the status conditions that the command byte enables. The word length and the presence of a parity bit in the received frame are fixed at build time.

Top module: `sap_front`

## Requirements
- R1: Register select 00 addresses the data registers: a write loads the transmit holding register and a read returns the receive holding register. Select 01 reads the status byte. Select 10 reads and writes the command byte. Select 11 reads as 00. Writes to 01 and 11 change nothing.
- R2: A register access happens only on a clock edge at which phi_hi and cs are both high; rw high selects a read and rw low a write. d_oe is high only during such a read, and d_out is zero whenever d_oe is low.
- R3: A synchronous reset, taken on a clock edge while rst_n is low, returns the block to this state: status reads 0x10 (transmit empty only), the command byte is 0x00, the receive holding register is 0x00, tx_full is 0 and irq_n is 1.
- R4: Received data is presented in the low WORD_BITS bits, with the first received bit in bit 0. All higher bits read as zero. The parity bit, which sits at frame position WORD_BITS when PARITY_EN=1, is never stored.
- R5: Status bit 3 (receive full) is set on the edge where rx_valid is high and cleared by a read of the data register. When both happen on the same edge, the new frame is loaded and bit 3 stays set.
- R6: Status bit 4 (transmit empty) is cleared by a write of the data register and set by tx_taken. A write wins when both occur on the same edge. tx_full is the inverse of bit 4, and tx_word carries the low WORD_BITS bits of the last byte written.
- R7: Status bits 5 and 6 latch high on any edge where dcd_lvl or dsr_lvl, respectively, is high. A status read clears them, and they latch again on the next edge if the level is still high.
- R8: Command bits 0, 1, 2 and 3 enable the receive-full, transmit-empty, carrier and data-set-ready causes. Status bit 7 is set on the edge after any enabled cause is present. Bits 2..0 of status read zero.
- R9: irq_n is the inverse of status bit 7. A status read clears bit 7, and bit 7 is set again one edge later if an enabled cause persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phi_hi | input | 1 | Bus phase high; transfers only when set |
| cs | input | 1 | Chip select, active high |
| rw | input | 1 | 1 = processor read, 0 = processor write |
| rs | input | 2 | Register select |
| d_in | input | 8 | Write data from the processor |
| d_out | output | 8 | Read data to the processor |
| d_oe | output | 1 | Data bus drive enable |
| irq_n | output | 1 | Interrupt request, active low |
| rx_valid | input | 1 | One-cycle strobe: received frame present |
| rx_frame | input | WORD_BITS+PARITY_EN | Received frame, first bit at bit 0 |
| tx_taken | input | 1 | One-cycle strobe: transmitter consumed the held byte |
| tx_word | output | WORD_BITS | Byte waiting for the transmitter |
| tx_full | output | 1 | Transmit holding register occupied |
| dcd_lvl | input | 1 | Carrier-detect level, 1 = asserted |
| dsr_lvl | input | 1 | Data-set-ready level, 1 = asserted |

## Verification
The bench builds the block with its defaults, WORD_BITS=7 and PARITY_EN=1. With these values the received frame is eight bits wide, and its top bit is a parity bit that must disappear. Frames whose parity bit is set can therefore be told apart from frames whose high data bit is set, which exercises both the parity stripping and the zeroing of the unused bit 7. With a seven-bit transmit word, a written 0xFF must come out as 0x7F, which shows that the truncation of tx_word is in place.

// File: rtl/sap_pkg.sv
package sap_pkg;
    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        SEL_DATA = 2'b00,
        SEL_STAT = 2'b01,
        SEL_CMD  = 2'b10,
        SEL_NONE = 2'b11
    } sel_e;

    typedef struct packed {
        logic       irq;
        logic       dsr;
        logic       dcd;
        logic       txe;
        logic       rxf;
        logic [2:0] zero;
    } stat_t;

    typedef struct packed {
        logic [3:0] spare;
        logic       en_dsr;
        logic       en_dcd;
        logic       en_txe;
        logic       en_rxf;
    } cmd_t;

    typedef struct packed {
        logic rd_data;
        logic rd_stat;
        logic rd_cmd;
        logic wr_data;
        logic wr_cmd;
    } acc_t;

    function automatic logic any_cause(input cmd_t c, input logic rxf, input logic txe,
                                       input logic dcd, input logic dsr);
        return (c.en_rxf & rxf) | (c.en_txe & txe) | (c.en_dcd & dcd) | (c.en_dsr & dsr);
    endfunction
endpackage

// File: rtl/sap_decode.sv
module sap_decode
    import sap_pkg::*;
(
    input  logic phi_hi,
    input  logic cs,
    input  logic rw,
    input  sel_e sel,
    output acc_t acc,
    output logic oe
);
    logic live;
    logic wr;

    always_comb begin
        live        = phi_hi & cs;
        oe          = live & rw;
        wr          = live & ~rw;
        acc.rd_data = oe & (sel == SEL_DATA);
        acc.rd_stat = oe & (sel == SEL_STAT);
        acc.rd_cmd  = oe & (sel == SEL_CMD);
        acc.wr_data = wr & (sel == SEL_DATA);
        acc.wr_cmd  = wr & (sel == SEL_CMD);
    end
endmodule

// File: rtl/sap_rx_hold.sv
module sap_rx_hold
    import sap_pkg::*;
#(
    parameter int WORD_BITS = 7,
    parameter int PARITY_EN = 1,
    localparam int FRAME_W  = WORD_BITS + PARITY_EN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [FRAME_W-1:0] rx_frame,
    input  logic               rd_data,
    output logic [BUS_W-1:0]   rx_byte,
    output logic               rxf
);
    logic [BUS_W-1:0] shaped;

    // keep the data bits only; parity and unused high bits become zero
    for (genvar i = 0; i < BUS_W; i++) begin : g_bit
        if (i < WORD_BITS) begin : g_data
            assign shaped[i] = rx_frame[i];
        end else begin : g_zero
            assign shaped[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte <= '0;
            rxf     <= 1'b0;
        end else if (rx_valid) begin
            rx_byte <= shaped;
            rxf     <= 1'b1;
        end else if (rd_data) begin
            rxf     <= 1'b0;
        end
    end
endmodule

// File: rtl/sap_tx_hold.sv
module sap_tx_hold
    import sap_pkg::*;
#(
    parameter int WORD_BITS = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_data,
    input  logic [BUS_W-1:0]     din,
    input  logic                 tx_taken,
    output logic [WORD_BITS-1:0] tx_word,
    output logic                 txe
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word <= '0;
            txe     <= 1'b1;
        end else if (wr_data) begin
            tx_word <= din[WORD_BITS-1:0];
            txe     <= 1'b0;
        end else if (tx_taken) begin
            txe     <= 1'b1;
        end
    end
endmodule

// File: rtl/sap_intr.sv
module sap_intr
    import sap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_t cmd,
    input  logic rxf,
    input  logic txe,
    input  logic dcd_lvl,
    input  logic dsr_lvl,
    input  logic rd_stat,
    output logic dcd_f,
    output logic dsr_f,
    output logic irq_f
);
    logic cause;

    always_comb cause = any_cause(cmd, rxf, txe, dcd_lvl, dsr_lvl);

    always_ff @(posedge clk) begin
        if (!rst_n || rd_stat) begin
            dcd_f <= 1'b0;
            dsr_f <= 1'b0;
            irq_f <= 1'b0;
        end else begin
            dcd_f <= dcd_f | dcd_lvl;
            dsr_f <= dsr_f | dsr_lvl;
            irq_f <= irq_f | cause;
        end
    end
endmodule

// File: rtl/sap_front.sv
module sap_front
    import sap_pkg::*;
#(
    parameter int WORD_BITS = 7,
    parameter int PARITY_EN = 1,
    localparam int FRAME_W  = WORD_BITS + PARITY_EN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 phi_hi,
    input  logic                 cs,
    input  logic                 rw,
    input  logic [1:0]           rs,
    input  logic [7:0]           d_in,
    output logic [7:0]           d_out,
    output logic                 d_oe,
    output logic                 irq_n,
    input  logic                 rx_valid,
    input  logic [FRAME_W-1:0]   rx_frame,
    input  logic                 tx_taken,
    output logic [WORD_BITS-1:0] tx_word,
    output logic                 tx_full,
    input  logic                 dcd_lvl,
    input  logic                 dsr_lvl
);
    acc_t             acc;
    cmd_t             cmd_q;
    stat_t            stat_q;
    logic [BUS_W-1:0] rx_byte;
    logic             rxf, txe, dcd_f, dsr_f, irq_f;

    sap_decode u_dec (
        .phi_hi (phi_hi),
        .cs     (cs),
        .rw     (rw),
        .sel    (sel_e'(rs)),
        .acc    (acc),
        .oe     (d_oe)
    );

    sap_rx_hold #(.WORD_BITS(WORD_BITS), .PARITY_EN(PARITY_EN)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_frame (rx_frame),
        .rd_data  (acc.rd_data),
        .rx_byte  (rx_byte),
        .rxf      (rxf)
    );

    sap_tx_hold #(.WORD_BITS(WORD_BITS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (acc.wr_data),
        .din      (d_in),
        .tx_taken (tx_taken),
        .tx_word  (tx_word),
        .txe      (txe)
    );

    sap_intr u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd_q),
        .rxf     (rxf),
        .txe     (txe),
        .dcd_lvl (dcd_lvl),
        .dsr_lvl (dsr_lvl),
        .rd_stat (acc.rd_stat),
        .dcd_f   (dcd_f),
        .dsr_f   (dsr_f),
        .irq_f   (irq_f)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)          cmd_q <= '0;
        else if (acc.wr_cmd) cmd_q <= cmd_t'(d_in);
    end

    always_comb begin
        stat_q.irq  = irq_f;
        stat_q.dsr  = dsr_f;
        stat_q.dcd  = dcd_f;
        stat_q.txe  = txe;
        stat_q.rxf  = rxf;
        stat_q.zero = '0;
    end

    always_comb begin
        d_out = '0;
        if (acc.rd_data)      d_out = rx_byte;
        else if (acc.rd_stat) d_out = stat_q;
        else if (acc.rd_cmd)  d_out = cmd_q;
    end

    assign irq_n   = ~irq_f;
    assign tx_full = ~txe;
endmodule

// File: rtl/sap_front_chk.sv
module sap_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       phi_hi,
    input logic       cs,
    input logic       rw,
    input logic [1:0] rs,
    input logic       rx_valid,
    input logic       tx_taken,
    input logic       dcd_lvl,
    input logic       dsr_lvl,
    input logic       d_oe,
    input logic       irq_n,
    input logic       tx_full,
    input logic [7:0] cmd_bits,
    input logic [7:0] stat_bits,
    input logic [4:0] acc_bits
);
    logic wr_dat, rd_st, live_cause;

    always_comb begin
        wr_dat     = phi_hi && cs && !rw && (rs == 2'b00);
        rd_st      = phi_hi && cs && rw && (rs == 2'b01);
        live_cause = (cmd_bits[0] && stat_bits[3]) || (cmd_bits[1] && stat_bits[4]) ||
                     (cmd_bits[2] && dcd_lvl) || (cmd_bits[3] && dsr_lvl);
    end

    // R2
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe |-> (phi_hi && cs && rw));

    // R1
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_bits));

    // R6
    tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dat |=> tx_full);

    // R6
    tx_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_taken && !wr_dat) |=> !tx_full);

    // R5
    rx_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> stat_bits[3]);

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cause && !rd_st) |=> !irq_n);

    // R9
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_st && !live_cause) |=> irq_n);
endmodule

bind sap_front sap_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phi_hi    (phi_hi),
    .cs        (cs),
    .rw        (rw),
    .rs        (rs),
    .rx_valid  (rx_valid),
    .tx_taken  (tx_taken),
    .dcd_lvl   (dcd_lvl),
    .dsr_lvl   (dsr_lvl),
    .d_oe      (d_oe),
    .irq_n     (irq_n),
    .tx_full   (tx_full),
    .cmd_bits  (cmd_q),
    .stat_bits (stat_q),
    .acc_bits  (acc)
);

// File: tb/sap_front_bench.sv
module sap_front_bench;
    localparam int WB = 7;
    localparam int PE = 1;
    localparam int FW = WB + PE;
    localparam int NV = 20;

    // entry: {req[3:0], kind[1:0], rs[1:0], data[7:0], exp[7:0]}
    // kind 0 = write, 1 = read and compare, 2 = inject frame, 3 = taken strobe
    localparam logic [23:0] VEC [NV] = '{
        {4'd3, 2'd1, 2'd1, 8'h00, 8'h10},
        {4'd1, 2'd0, 2'd2, 8'h30, 8'h00},
        {4'd1, 2'd1, 2'd2, 8'h00, 8'h30},
        {4'd5, 2'd2, 2'd0, 8'hD5, 8'h00},
        {4'd5, 2'd1, 2'd1, 8'h00, 8'h18},
        {4'd4, 2'd1, 2'd0, 8'h00, 8'h55},
        {4'd5, 2'd1, 2'd1, 8'h00, 8'h10},
        {4'd6, 2'd0, 2'd0, 8'hFF, 8'h00},
        {4'd6, 2'd1, 2'd1, 8'h00, 8'h00},
        {4'd6, 2'd3, 2'd0, 8'h00, 8'h00},
        {4'd6, 2'd1, 2'd1, 8'h00, 8'h10},
        {4'd4, 2'd2, 2'd0, 8'hAA, 8'h00},
        {4'd4, 2'd1, 2'd0, 8'h00, 8'h2A},
        {4'd4, 2'd2, 2'd0, 8'h7F, 8'h00},
        {4'd4, 2'd1, 2'd0, 8'h00, 8'h7F},
        {4'd1, 2'd1, 2'd3, 8'h00, 8'h00},
        {4'd1, 2'd0, 2'd3, 8'hFF, 8'h00},
        {4'd1, 2'd1, 2'd2, 8'h00, 8'h30},
        {4'd1, 2'd0, 2'd1, 8'hFF, 8'h00},
        {4'd1, 2'd1, 2'd1, 8'h00, 8'h10}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          phi_hi = 1'b0, cs = 1'b0, rw = 1'b1;
    logic [1:0]    rs = 2'b00;
    logic [7:0]    d_in = 8'h00;
    logic [7:0]    d_out;
    logic          d_oe, irq_n;
    logic          rx_valid = 1'b0;
    logic [FW-1:0] rx_frame = '0;
    logic          tx_taken = 1'b0;
    logic [WB-1:0] tx_word;
    logic          tx_full;
    logic          dcd_lvl = 1'b0, dsr_lvl = 1'b0;

    int checks = 0;
    int failures = 0;

    sap_front #(.WORD_BITS(WB), .PARITY_EN(PE)) u_sap_front (
        .clk(clk), .rst_n(rst_n), .phi_hi(phi_hi), .cs(cs), .rw(rw), .rs(rs),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .irq_n(irq_n),
        .rx_valid(rx_valid), .rx_frame(rx_frame), .tx_taken(tx_taken),
        .tx_word(tx_word), .tx_full(tx_full), .dcd_lvl(dcd_lvl), .dsr_lvl(dsr_lvl)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_op(input bit wr, input logic [1:0] sel, input logic [7:0] wd,
                          output logic [7:0] rd);
        @(negedge clk);
        phi_hi = 1'b1; cs = 1'b1; rw = ~wr; rs = sel; d_in = wd;
        #1 rd = d_out;
        @(posedge clk);
        #1 phi_hi = 1'b0; cs = 1'b0; rw = 1'b1;
    endtask

    task automatic inject(input logic [FW-1:0] f);
        @(negedge clk);
        rx_valid = 1'b1; rx_frame = f;
        @(posedge clk);
        #1 rx_valid = 1'b0;
    endtask

    task automatic taken();
        @(negedge clk);
        tx_taken = 1'b1;
        @(posedge clk);
        #1 tx_taken = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        do_reset();
        // R3 reset state at the ports
        chk("R3 irq_n after reset", {7'h0, irq_n}, 8'h01);
        chk("R3 tx_full after reset", {7'h0, tx_full}, 8'h00);
        chk("R2 d_out idle", d_out, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            v = VEC[i];
            case (v[19:18])
                2'd0: bus_op(1'b1, v[17:16], v[15:8], r);
                2'd1: begin
                    bus_op(1'b0, v[17:16], 8'h00, r);
                    chk($sformatf("R%0d vector %0d", v[23:20], i), r, v[7:0]);
                end
                2'd2: inject(v[15:8]);
                default: taken();
            endcase
        end

        // R6 truncated transmit word and occupancy
        bus_op(1'b1, 2'd0, 8'hFF, r);
        chk("R6 tx_word", {1'b0, tx_word}, 8'h7F);
        chk("R6 tx_full", {7'h0, tx_full}, 8'h01);
        // R6 write and taken on the same edge: write wins
        @(negedge clk);
        phi_hi = 1'b1; cs = 1'b1; rw = 1'b0; rs = 2'd0; d_in = 8'h41; tx_taken = 1'b1;
        @(posedge clk);
        #1 phi_hi = 1'b0; cs = 1'b0; rw = 1'b1; tx_taken = 1'b0;
        chk("R6 write beats taken", {7'h0, tx_full}, 8'h01);
        chk("R6 tx_word new", {1'b0, tx_word}, 8'h41);

        // R5 arrival and data read on the same edge
        do_reset();
        inject(8'h11);
        @(negedge clk);
        phi_hi = 1'b1; cs = 1'b1; rw = 1'b1; rs = 2'd0; rx_valid = 1'b1; rx_frame = 8'h22;
        #1 r = d_out;
        @(posedge clk);
        #1 phi_hi = 1'b0; cs = 1'b0; rx_valid = 1'b0;
        chk("R5 old byte returned", r, 8'h11);
        bus_op(1'b0, 2'd1, 8'h00, r);
        chk("R5 full kept on collision", r, 8'h18);
        bus_op(1'b0, 2'd0, 8'h00, r);
        chk("R4 new byte", r, 8'h22);

        // R2 no transfer without phase high or without select
        do_reset();
        @(negedge clk);
        phi_hi = 1'b0; cs = 1'b1; rw = 1'b0; rs = 2'd0; d_in = 8'hAA;
        @(posedge clk);
        #1 cs = 1'b0; rw = 1'b1;
        chk("R2 phase-low write ignored", {7'h0, tx_full}, 8'h00);
        @(negedge clk);
        phi_hi = 1'b1; cs = 1'b0; rw = 1'b0; rs = 2'd2; d_in = 8'hFF;
        @(posedge clk);
        #1 phi_hi = 1'b0; rw = 1'b1;
        bus_op(1'b0, 2'd2, 8'h00, r);
        chk("R2 unselected write ignored", r, 8'h00);
        @(negedge clk);
        phi_hi = 1'b0; cs = 1'b1; rw = 1'b1; rs = 2'd1;
        #1 chk("R2 no drive in low phase", {7'h0, d_oe}, 8'h00);
        chk("R2 d_out zero undriven", d_out, 8'h00);
        @(posedge clk);
        #1 cs = 1'b0;

        // R8 receive-full cause enabled
        do_reset();
        bus_op(1'b1, 2'd2, 8'h01, r);
        idle(2);
        chk("R8 no cause yet", {7'h0, irq_n}, 8'h01);
        inject(8'h05);
        idle(2);
        chk("R8 irq on rx full", {7'h0, irq_n}, 8'h00);
        bus_op(1'b0, 2'd0, 8'h00, r);
        idle(1);
        chk("R9 summary sticky", {7'h0, irq_n}, 8'h00);
        bus_op(1'b0, 2'd1, 8'h00, r);
        chk("R8 status with summary", r, 8'h90);
        chk("R9 cleared by status read", {7'h0, irq_n}, 8'h01);
        idle(2);
        chk("R9 stays clear", {7'h0, irq_n}, 8'h01);

        // R9 persistent transmit-empty cause returns
        bus_op(1'b1, 2'd2, 8'h02, r);
        idle(2);
        chk("R8 irq on tx empty", {7'h0, irq_n}, 8'h00);
        bus_op(1'b0, 2'd1, 8'h00, r);
        chk("R9 read gap", {7'h0, irq_n}, 8'h01);
        idle(1);
        chk("R9 reasserts", {7'h0, irq_n}, 8'h00);

        // R7 carrier latch, interrupts disabled
        do_reset();
        @(negedge clk);
        dcd_lvl = 1'b1;
        @(posedge clk);
        #1 dcd_lvl = 1'b0;
        bus_op(1'b0, 2'd1, 8'h00, r);
        chk("R7 carrier latched", r, 8'h30);
        bus_op(1'b0, 2'd1, 8'h00, r);
        chk("R7 carrier cleared", r, 8'h10);
        chk("R8 disabled cause silent", {7'h0, irq_n}, 8'h01);
        bus_op(1'b1, 2'd2, 8'h08, r);
        dsr_lvl = 1'b1;
        idle(2);
        chk("R8 irq on data-set-ready", {7'h0, irq_n}, 8'h00);
        bus_op(1'b0, 2'd1, 8'h00, r);
        chk("R7 dsr status", r, 8'hD0);
        idle(1);
        bus_op(1'b0, 2'd1, 8'h00, r);
        chk("R7 dsr relatched", r, 8'hD0);
        dsr_lvl = 1'b0;

        // R3 reset in the middle of activity
        bus_op(1'b1, 2'd2, 8'h0F, r);
        bus_op(1'b1, 2'd0, 8'h33, r);
        inject(8'h44);
        idle(2);
        do_reset();
        chk("R3 irq_n", {7'h0, irq_n}, 8'h01);
        chk("R3 tx_full", {7'h0, tx_full}, 8'h00);
        bus_op(1'b0, 2'd1, 8'h00, r);
        chk("R3 status", r, 8'h10);
        bus_op(1'b0, 2'd2, 8'h00, r);
        chk("R3 command", r, 8'h00);
        bus_op(1'b0, 2'd0, 8'h00, r);
        chk("R3 receive register", r, 8'h00);

        finish_run();
    end
endmodule